// File: doc/BRIEF.md
# Configurable-Format Serial Transmitter

This block turns characters into an asynchronous serial stream on one output line. A mode word sets the character format. It selects six, seven or eight data bits, one of four parity rules or no parity bit, and one or two stop bits. Characters arrive over a valid/ready handshake, one per transfer. A free-running bit-rate tick input sets the pace: every serial bit lasts a fixed number of ticks.

A one-cycle control write strobe carries a small command word. The command word can enable the transmitter, disable it, start or stop a line break, and reset the transmit logic. Two status outputs report what the block is doing. One shows that a character is being shifted. The other shows that the line is fully idle, meaning no character is in flight and no break is being held. The block has no character buffer, baud generator or register file of its own. The surrounding logic supplies those.

Top module: `cfg_uart_tx`

## Requirements
- R1: After reset the line is high, `idle_o` is 1, `busy_o` is 0 and `ready_o` is 0, because the transmitter starts disabled.
- R2: An accepted character is sent as one low start bit, then its data bits least significant first. Mode bits [2:1] set the count: 2'b11 sends 6 bits, 2'b10 sends 7, and 2'b00 or 2'b01 send 8. Data bits above the selected count are not sent.
- R3: Mode bits [5:3] choose the bit that follows the last data bit. 3'b000 gives even parity over the sent data bits and 3'b001 gives odd parity. 3'b010 always sends 0 and 3'b011 always sends 1. Any code 3'b1xx sends no parity bit.
- R4: Stop bits are driven high. Mode bit 7 set gives two stop bits and clear gives one.
- R5: Each serial bit lasts exactly TICKS_PER_BIT (default 16) cycles of `tick_i`. Clock cycles without a tick do not advance the line, so at one tick every three clocks a 10-bit character stays busy for about 480 clocks.
- R6: The format and data are captured when the handshake completes. Changing `mode_i` or `data_i` afterwards does not alter the character in flight.
- R7: Control word bit 1 enables the transmitter and bit 2 disables it. When both are written together, disable wins. `ready_o` is high only when the transmitter is enabled, no character is shifting and no break is active.
- R8: A disable written while a character is shifting lets that character finish intact. After it finishes, `ready_o` stays low.
- R9: Control bit 3 starts a break, which holds the line low continuously, even over a character in flight. Control bit 4 ends the break and returns the idle line to high. If both are written together, the break-end command wins.
- R10: Control bit 0 is a transmit reset. In the write cycle `ready_o` is low. On the next cycle the shifting character has been dropped, the break is cleared, `busy_o` is 0 and the line is high.
- R11: `idle_o` is 1 exactly when no character is shifting and no break is active, and the line is high whenever `idle_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Bit-rate tick, one clock wide per pulse |
| mode_i | input | 8 | Format word: [2:1] length, [5:3] parity, [7] stop count |
| ctrl_wr_i | input | 1 | Strobe marking a valid control word |
| ctrl_i | input | 5 | Commands: [0] reset, [1] enable, [2] disable, [3] break on, [4] break off |
| data_i | input | 8 | Character to send |
| valid_i | input | 1 | Character offered |
| ready_o | output | 1 | Character can be accepted this cycle |
| txd_o | output | 1 | Serial line, high when idle |
| busy_o | output | 1 | A character is being shifted |
| idle_o | output | 1 | No character shifting and no break held |

## Verification
The bench sweeps every length code, including the 2'b01 alias, over six parity codes and both stop settings, using data values whose upper bits would change parity if they leaked in. A design that sized the parity over all eight bits, or that decoded the alias as some other length, puts a wrong bit at a known position. Each handshake is followed at once by an inverted mode and data word, so a design that keeps reading its inputs instead of latching them garbles the character. The remaining cases are:
- a disable written mid-character, which a design with the wrong priority would cut short;
- a combined enable-and-disable write;
- a combined break-on-and-break-off write;
- a break laid over a character, followed by a transmit reset, where the line must go low and then recover to high with `busy_o` cleared;
- a slow tick rate, which exposes a design that counts clocks instead of ticks.

// File: rtl/cfg_uart_tx_pkg.sv
package cfg_uart_tx_pkg;
   // Command word bit positions
   localparam int CW_RESET   = 0;
   localparam int CW_ENABLE  = 1;
   localparam int CW_DISABLE = 2;
   localparam int CW_BRK_ON  = 3;
   localparam int CW_BRK_OFF = 4;
   localparam int CTRL_W     = 5;

   localparam int MODE_W     = 8;
   localparam int CHAR_W     = 8;
   // start + data + parity + two stops
   localparam int FRAME_W    = 1 + CHAR_W + 1 + 2;
   localparam int NB_W       = $clog2(FRAME_W + 1);

   typedef enum logic [1:0] {
      PAR_EVEN  = 2'b00,
      PAR_ODD   = 2'b01,
      PAR_SPACE = 2'b10,
      PAR_MARK  = 2'b11
   } par_kind_t;
endpackage

// File: rtl/cfg_uart_tx_ctrl.sv
module cfg_uart_tx_ctrl
   import cfg_uart_tx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [CTRL_W-1:0] cmd_i,
   output logic              en_o,
   output logic              brk_o,
   output logic              clr_o
);
   logic en_q, brk_q;

   assign clr_o = wr_i & cmd_i[CW_RESET];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         brk_q <= 1'b0;
      end else if (wr_i) begin
         if (cmd_i[CW_DISABLE])
            en_q <= 1'b0;
         else if (cmd_i[CW_ENABLE])
            en_q <= 1'b1;

         if (cmd_i[CW_RESET] || cmd_i[CW_BRK_OFF])
            brk_q <= 1'b0;
         else if (cmd_i[CW_BRK_ON])
            brk_q <= 1'b1;
      end
   end

   assign en_o  = en_q;
   assign brk_o = brk_q;
endmodule

// File: rtl/cfg_uart_tx_framer.sv
module cfg_uart_tx_framer
   import cfg_uart_tx_pkg::*;
(
   input  logic [CHAR_W-1:0]  data_i,
   input  logic [1:0]         len_code_i,
   input  logic [2:0]         par_code_i,
   input  logic               two_stop_i,
   output logic [FRAME_W-1:0] frame_o,
   output logic [NB_W-1:0]    nbits_o
);
   logic [NB_W-1:0]   dlen;
   logic [CHAR_W-1:0] dmask;
   logic              par_en;
   logic              par_bit;
   par_kind_t         kind;

   always_comb begin
      case (len_code_i)
         2'b11:   dlen = NB_W'(6);
         2'b10:   dlen = NB_W'(7);
         default: dlen = NB_W'(8);
      endcase
   end

   for (genvar i = 0; i < CHAR_W; i++) begin : g_mask
      assign dmask[i] = data_i[i] & (NB_W'(i) < dlen);
   end

   assign par_en = ~par_code_i[2];
   assign kind   = par_kind_t'(par_code_i[1:0]);

   always_comb begin
      case (kind)
         PAR_EVEN:  par_bit = ^dmask;
         PAR_ODD:   par_bit = ~(^dmask);
         PAR_SPACE: par_bit = 1'b0;
         default:   par_bit = 1'b1;
      endcase
   end

   assign frame_o[0] = 1'b0;
   for (genvar p = 1; p < FRAME_W; p++) begin : g_pos
      if (p <= CHAR_W) begin : g_dat
         assign frame_o[p] = (NB_W'(p) <= dlen) ? data_i[p-1] :
                             (par_en && NB_W'(p) == dlen + NB_W'(1)) ? par_bit : 1'b1;
      end else begin : g_tail
         assign frame_o[p] = (par_en && NB_W'(p) == dlen + NB_W'(1)) ? par_bit : 1'b1;
      end
   end

   assign nbits_o = NB_W'(1) + dlen + NB_W'(par_en) + (two_stop_i ? NB_W'(2) : NB_W'(1));
endmodule

// File: rtl/cfg_uart_tx_shifter.sv
module cfg_uart_tx_shifter
   import cfg_uart_tx_pkg::*;
#(
   parameter int TICKS_PER_BIT = 16
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_i,
   input  logic               load_i,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic [NB_W-1:0]    nbits_i,
   input  logic               tick_i,
   output logic               busy_o,
   output logic               line_o
);
   localparam int TC_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
   localparam logic [TC_W-1:0] TC_LAST = TC_W'(TICKS_PER_BIT - 1);

   logic [FRAME_W-1:0] sh_q;
   logic [NB_W-1:0]    left_q;
   logic [TC_W-1:0]    tc_q;
   logic               busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '1;
         left_q <= '0;
         tc_q   <= '0;
         busy_q <= 1'b0;
      end else if (clr_i) begin
         sh_q   <= '1;
         left_q <= '0;
         tc_q   <= '0;
         busy_q <= 1'b0;
      end else if (load_i) begin
         sh_q   <= frame_i;
         left_q <= nbits_i;
         tc_q   <= '0;
         busy_q <= 1'b1;
      end else if (busy_q && tick_i) begin
         if (tc_q == TC_LAST) begin
            tc_q <= '0;
            if (left_q == NB_W'(1)) begin
               busy_q <= 1'b0;
               sh_q   <= '1;
               left_q <= '0;
            end else begin
               sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
               left_q <= left_q - NB_W'(1);
            end
         end else begin
            tc_q <= tc_q + TC_W'(1);
         end
      end
   end

   assign busy_o = busy_q;
   assign line_o = sh_q[0];
endmodule

// File: rtl/cfg_uart_tx.sv
module cfg_uart_tx
   import cfg_uart_tx_pkg::*;
#(
   parameter int TICKS_PER_BIT = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              ctrl_wr_i,
   input  logic [CTRL_W-1:0] ctrl_i,
   input  logic [CHAR_W-1:0] data_i,
   input  logic              valid_i,
   output logic              ready_o,
   output logic              txd_o,
   output logic              busy_o,
   output logic              idle_o
);
   if (TICKS_PER_BIT < 2) begin : g_bad_tpb
      $error("cfg_uart_tx: TICKS_PER_BIT must be at least 2");
   end

   logic               en, brk, clr, busy, line, load;
   logic [FRAME_W-1:0] frame;
   logic [NB_W-1:0]    nbits;
   logic               unused_mode_bits;

   assign unused_mode_bits = ^{mode_i[6], mode_i[0]};

   cfg_uart_tx_ctrl u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_i  (ctrl_wr_i),
      .cmd_i (ctrl_i),
      .en_o  (en),
      .brk_o (brk),
      .clr_o (clr)
   );

   cfg_uart_tx_framer u_framer (
      .data_i     (data_i),
      .len_code_i (mode_i[2:1]),
      .par_code_i (mode_i[5:3]),
      .two_stop_i (mode_i[7]),
      .frame_o    (frame),
      .nbits_o    (nbits)
   );

   cfg_uart_tx_shifter #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr),
      .load_i  (load),
      .frame_i (frame),
      .nbits_i (nbits),
      .tick_i  (tick_i),
      .busy_o  (busy),
      .line_o  (line)
   );

   assign ready_o = en & ~busy & ~brk & ~clr;
   assign load    = valid_i & ready_o;
   assign txd_o   = brk ? 1'b0 : line;
   assign busy_o  = busy;
   assign idle_o  = ~busy & ~brk;
endmodule

// File: rtl/cfg_uart_tx_chk.sv
module cfg_uart_tx_chk
   import cfg_uart_tx_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              ctrl_wr_i,
   input logic [CTRL_W-1:0] ctrl_i,
   input logic              valid_i,
   input logic              ready_o,
   input logic              txd_o,
   input logic              busy_o,
   input logic              idle_o
);
   // R2
   start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && ready_o) |=> (busy_o && !txd_o));

   // R7
   dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr_i && ctrl_i[CW_DISABLE]) |=> !ready_o);

   // R7
   ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (idle_o && txd_o));

   // R9
   brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr_i && ctrl_i[CW_BRK_ON] && !ctrl_i[CW_BRK_OFF] && !ctrl_i[CW_RESET])
      |=> (!txd_o && !idle_o));

   // R9
   brk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr_i && ctrl_i[CW_BRK_OFF] && !busy_o && !(valid_i && ready_o))
      |=> (txd_o && idle_o));

   // R10
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr_i && ctrl_i[CW_RESET]) |-> (!ready_o ##1 (!busy_o && txd_o)));

   // R11
   idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_o |-> (txd_o && !busy_o));
endmodule

bind cfg_uart_tx cfg_uart_tx_chk u_cfg_uart_tx_chk (.*);

// File: tb/test_cfg_uart_tx.sv
module test_cfg_uart_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b1;
   logic [7:0] mode_i = 8'h00;
   logic       ctrl_wr_i = 1'b0;
   logic [4:0] ctrl_i = 5'd0;
   logic [7:0] data_i = 8'h00;
   logic       valid_i = 1'b0;
   logic       ready_o, txd_o, busy_o, idle_o;

   int n_chk = 0;
   int n_fail = 0;
   int tick_period = 1;
   bit done = 0;

   localparam logic [4:0] C_RST = 5'b00001, C_EN = 5'b00010, C_DIS = 5'b00100,
                          C_BON = 5'b01000, C_BOFF = 5'b10000;

   always #2 clk = ~clk;

   cfg_uart_tx i_cfg_uart_tx (.*);

   initial begin : tick_gen
      int ph = 0;
      forever begin
         @(negedge clk);
         ph = (ph + 1) % tick_period;
         tick_i = (tick_period == 1) || (ph == 0);
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic ctrl_write(input logic [4:0] v);
      @(negedge clk); ctrl_wr_i = 1'b1; ctrl_i = v;
      @(negedge clk); ctrl_wr_i = 1'b0; ctrl_i = 5'd0;
   endtask

   task automatic start_char(input logic [7:0] d, input logic [7:0] m);
      @(negedge clk); data_i = d; mode_i = m; valid_i = 1'b1;
      @(negedge clk); valid_i = 1'b0;
   endtask

   // Sends one character and checks each bit at its centre (tick every clock).
   task automatic send_check(input logic [7:0] d, input logic [7:0] m, input logic [4:0] mid);
      int len, ones, n;
      bit pen, pv;
      logic [11:0] eb;
      string tag;
      len  = (m[2:1] == 2'b11) ? 6 : (m[2:1] == 2'b10) ? 7 : 8;
      ones = 0;
      for (int i = 0; i < len; i++) ones += d[i];
      pen = (m[5] == 1'b0);
      case (m[4:3])
         2'b00: pv = (ones % 2) == 1;
         2'b01: pv = (ones % 2) == 0;
         2'b10: pv = 1'b0;
         default: pv = 1'b1;
      endcase
      eb = '1;
      eb[0] = 1'b0;
      for (int i = 0; i < len; i++) eb[1+i] = d[i];
      if (pen) eb[1+len] = pv;
      n = 1 + len + int'(pen) + (m[7] ? 2 : 1);

      @(negedge clk);
      chk("R7 ready before send", 32'(ready_o), 32'd1);
      data_i = d; mode_i = m; valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0; mode_i = ~m; data_i = ~d;   // R6: later input changes ignored
      repeat (8) @(negedge clk);
      for (int k = 0; k < n; k++) begin
         if (k <= len)                tag = "R2 R6 data/start bit";
         else if (pen && k == len + 1) tag = "R3 R6 parity bit";
         else                         tag = "R4 R6 stop bit";
         chk(tag, 32'(txd_o), 32'(eb[k]));
         chk("R11 busy during char", 32'(busy_o), 32'd1);
         if (k < n - 1) begin
            if (k == 1 && mid != 5'd0) begin
               ctrl_wr_i = 1'b1; ctrl_i = mid;
               @(negedge clk);
               ctrl_wr_i = 1'b0; ctrl_i = 5'd0;
               repeat (15) @(negedge clk);
            end else begin
               repeat (16) @(negedge clk);
            end
         end
      end
      repeat (7) @(negedge clk);
      chk("R5 busy until last tick", 32'(busy_o), 32'd1);
      @(negedge clk);
      chk("R5 done after N*16 ticks", 32'(busy_o), 32'd0);
      chk("R11 idle after char", 32'(idle_o), 32'd1);
      chk("R4 line high after char", 32'(txd_o), 32'd1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin : main
      int plist [6] = '{0, 1, 2, 3, 4, 7};
      logic [7:0] dlist [5] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'hC1};
      logic [7:0] m;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 txd", 32'(txd_o), 32'd1);
      chk("R1 idle", 32'(idle_o), 32'd1);
      chk("R1 busy", 32'(busy_o), 32'd0);
      chk("R1 ready", 32'(ready_o), 32'd0);

      // R7 disabled: offered character is not taken
      @(negedge clk); valid_i = 1'b1;
      repeat (5) @(negedge clk);
      chk("R7 no accept while disabled busy", 32'(busy_o), 32'd0);
      chk("R7 no accept while disabled txd", 32'(txd_o), 32'd1);
      valid_i = 1'b0;

      ctrl_write(C_EN);
      chk("R7 enabled ready", 32'(ready_o), 32'd1);
      ctrl_write(C_EN | C_DIS);
      chk("R7 disable wins", 32'(ready_o), 32'd0);
      ctrl_write(C_EN);

      // Format sweep (R2 R3 R4 R5 R6)
      for (int lc = 0; lc < 4; lc++)
         for (int pi = 0; pi < 6; pi++)
            for (int sc = 0; sc < 2; sc++)
               for (int di = 0; di < 5; di++) begin
                  m = {1'(sc), 1'b0, 3'(plist[pi]), 2'(lc), 1'b0};
                  send_check(dlist[di], m, 5'd0);
               end

      // R8 disable mid character
      send_check(8'h96, 8'b1000_0000, C_DIS);
      chk("R8 ready low after finish", 32'(ready_o), 32'd0);
      ctrl_write(C_EN);

      // R9 break while idle
      ctrl_write(C_BON);
      repeat (20) @(negedge clk);
      chk("R9 break holds line low", 32'(txd_o), 32'd0);
      chk("R11 not idle in break", 32'(idle_o), 32'd0);
      chk("R7 not ready in break", 32'(ready_o), 32'd0);
      ctrl_write(C_BOFF);
      chk("R9 break end line high", 32'(txd_o), 32'd1);
      chk("R11 idle after break", 32'(idle_o), 32'd1);
      ctrl_write(C_BON | C_BOFF);
      chk("R9 break-off wins", 32'(txd_o), 32'd1);

      // R9 break over a character, then R10 reset clears it
      start_char(8'hFF, 8'b0010_0000);
      repeat (20) @(negedge clk);
      ctrl_write(C_BON);
      repeat (40) @(negedge clk);
      chk("R9 break overrides char", 32'(txd_o), 32'd0);
      ctrl_write(C_RST);
      chk("R10 reset clears busy", 32'(busy_o), 32'd0);
      chk("R10 reset clears break", 32'(txd_o), 32'd1);
      chk("R10 idle after reset", 32'(idle_o), 32'd1);

      // R10 reset mid character, ready low in the write cycle
      start_char(8'h00, 8'b0010_0000);
      repeat (30) @(negedge clk);
      ctrl_wr_i = 1'b1; ctrl_i = C_RST;
      #1;
      chk("R10 busy before reset edge", 32'(busy_o), 32'd1);
      @(negedge clk);
      ctrl_wr_i = 1'b0; ctrl_i = 5'd0;
      chk("R10 dropped char", 32'(busy_o), 32'd0);
      chk("R10 line high", 32'(txd_o), 32'd1);
      @(negedge clk);
      ctrl_wr_i = 1'b1; ctrl_i = C_RST;
      #1;
      chk("R10 ready low in reset write", 32'(ready_o), 32'd0);
      @(negedge clk);
      ctrl_wr_i = 1'b0; ctrl_i = 5'd0;

      // R5 pacing by ticks: one tick every 3 clocks, 10-bit character
      tick_period = 3;
      start_char(8'h5A, 8'b0010_0000);
      repeat (476) @(negedge clk);
      chk("R5 slow ticks still busy", 32'(busy_o), 32'd1);
      repeat (6) @(negedge clk);
      chk("R5 slow ticks finished", 32'(busy_o), 32'd0);
      tick_period = 1;

      done = 1;
      summary();
      $finish;
   end
endmodule